// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Transmitter

This block is the transmit side of a synchronous serial port that runs as a slave. It never makes a shift clock of its own. An external master drives the shift clock into `sclk_in`, and the block presents one data bit on `sdata_out` for each active edge of that clock, least significant bit first. The master samples each bit on the opposite edge. The external clock passes through a two-flop synchroniser and an edge detector, so all state stays in the system clock domain.

Transmit is double buffered. A host writes a word into a holding register. If the shift register is idle, the word moves into it on the next system clock and shifting starts. If a word is still shifting, the new word waits in the holding register and the holding-empty flag stays low. It is handed over only when the last bit of the current word has been shifted. An optional nine-bit mode adds a ninth bit, taken from a separate input, at the end of each word. The combination of the holding-empty flag and an interrupt enable gives a request that can also serve as a wake signal.

Top module: `sync_slave_tx`

## Requirements
- R1: While reset is active and straight after it, `shift_empty` = 1, `hold_empty` = 1, `irq_req` = 0 (when `irq_en` = 0) and `sdata_out` = 1.
- R2: The block transmits only while `port_en` = 1, `sync_mode` = 1, `master_sel` = 0, `rx_cont_en` = 0, `rx_single_en` = 0 and `tx_en` = 1. In any other case it discards writes, flushes any queued or shifting word, shows `hold_empty` = 1 and `shift_empty` = 1 from the next clock, and leaves `sdata_out` unchanged.
- R3: A word written while the shift register is empty and nothing is queued moves into the shift register on the clock after the write. From then on `shift_empty` = 0 and `hold_empty` = 1.
- R4: Bits leave least significant first, one bit per active external edge. With `clk_pol` = 0 the active edge is rising. With `clk_pol` = 1 it is falling. A new bit appears on `sdata_out` on the third system clock edge after the external edge.
- R5: A word written while another is shifting keeps `hold_empty` = 0 until the last bit of the current word has been shifted.
- R6: After the last bit of the current word, the queued word moves into the shift register, `hold_empty` returns to 1, and its first bit follows on the next active edge without a gap.
- R7: `irq_req` is 1 exactly when `hold_empty` = 1 and `irq_en` = 1.
- R8: With `nine_mode` = 1 each word carries nine bits. The ninth bit is the value of `ninth_bit` when the word enters the shift register, and it is sent last.
- R9: `shift_empty` returns to 1 after the shift edge of the final bit (8th, or 9th in nine-bit mode) when no word is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Shift clock from the external master |
| sdata_out | output | 1 | Serial data line |
| wr_hold | input | 1 | One-cycle write strobe for the holding register |
| wr_data | input | DW | Word to transmit |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | 1 selects synchronous operation |
| master_sel | input | 1 | Clock source select, 0 for slave |
| rx_cont_en | input | 1 | Continuous receive enable, must be 0 |
| rx_single_en | input | 1 | Single receive enable, must be 0 |
| tx_en | input | 1 | Transmit enable |
| nine_mode | input | 1 | 1 adds a ninth bit to each word |
| ninth_bit | input | 1 | Value of the ninth bit |
| clk_pol | input | 1 | 0: present on rising edge, 1: on falling edge |
| irq_en | input | 1 | Transmit interrupt enable |
| hold_empty | output | 1 | Holding register empty flag |
| shift_empty | output | 1 | Shift register empty status |
| irq_req | output | 1 | Interrupt and wake request |

## Verification
An external edge reaches `sdata_out` on the third system clock after it, so the bench, acting as the master, holds each shift-clock level for eight system clocks. It compares the data line just before it drives the opposite edge, against bits queued in LSB-first order when each word was written. Flag results fall due one clock after a write or a handoff. The bench reads `hold_empty` and `shift_empty` at the falling system clock edge after the write strobe, and at the end of a full shift-clock period, after the edge of a word's last bit. Flush and ignore cases are read one or more clocks after the condition, with the data line compared to the value recorded just before.

// File: rtl/sync_slave_tx.sv
module sync_slave_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_in,
  output logic          sdata_out,
  input  logic          wr_hold,
  input  logic [DW-1:0] wr_data,
  input  logic          port_en,
  input  logic          sync_mode,
  input  logic          master_sel,
  input  logic          rx_cont_en,
  input  logic          rx_single_en,
  input  logic          tx_en,
  input  logic          nine_mode,
  input  logic          ninth_bit,
  input  logic          clk_pol,
  input  logic          irq_en,
  output logic          hold_empty,
  output logic          shift_empty,
  output logic          irq_req
);
  localparam int CW = $clog2(DW + 2);

  logic [2:0]    sync_q;
  logic [DW-1:0] hold_q;
  logic          hold_full;
  logic [DW:0]   sh_q;
  logic [CW-1:0] cnt_q;
  logic          sh_empty_q;
  logic          sdata_q;

  wire active     = port_en & sync_mode & ~master_sel & ~rx_cont_en & ~rx_single_en & tx_en;
  wire rise_w     = sync_q[1] & ~sync_q[2];
  wire fall_w     = ~sync_q[1] & sync_q[2];
  wire shift_edge = clk_pol ? fall_w : rise_w;
  wire load       = active & hold_full & sh_empty_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], sclk_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else if (!active) begin
      hold_full <= 1'b0;
    end else if (wr_hold) begin
      hold_q    <= wr_data;
      hold_full <= 1'b1;
    end else if (load) begin
      hold_full <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_q       <= '0;
      cnt_q      <= '0;
      sh_empty_q <= 1'b1;
      sdata_q    <= 1'b1;
    end else if (!active) begin
      cnt_q      <= '0;
      sh_empty_q <= 1'b1;
    end else if (load) begin
      sh_q       <= {ninth_bit & nine_mode, hold_q};
      cnt_q      <= nine_mode ? CW'(DW + 1) : CW'(DW);
      sh_empty_q <= 1'b0;
    end else if (!sh_empty_q && shift_edge) begin
      sdata_q <= sh_q[0];
      sh_q    <= {1'b0, sh_q[DW:1]};
      cnt_q   <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) sh_empty_q <= 1'b1;
    end

  assign sdata_out   = sdata_q;
  assign hold_empty  = ~hold_full;
  assign shift_empty = sh_empty_q;
  assign irq_req     = hold_empty & irq_en;
endmodule

// File: rtl/sync_slave_tx_chk.sv
module sync_slave_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic active,
  input logic wr_hold,
  input logic sdata_out,
  input logic hold_empty,
  input logic shift_empty
);
  // R2
  inactive_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (hold_empty && shift_empty));

  // R2
  inactive_line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(sdata_out));

  // R3
  idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !hold_empty && shift_empty && !wr_hold) |=> (!shift_empty && hold_empty));

  // R5
  queued_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !hold_empty && !shift_empty) |=> !hold_empty);

  // R4
  line_moves_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_out) |-> ($past(active) && !$past(shift_empty)));
endmodule

bind sync_slave_tx sync_slave_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .wr_hold(wr_hold),
  .sdata_out(sdata_out), .hold_empty(hold_empty), .shift_empty(shift_empty)
);

// File: tb/test_sync_slave_tx.sv
module test_sync_slave_tx;
  localparam int DW = 8;
  localparam int H  = 8;

  logic clk = 0, rst_n = 0, sclk_in = 0, wr_hold = 0;
  logic [DW-1:0] wr_data = '0;
  logic port_en = 1, sync_mode = 1, master_sel = 0, rx_cont_en = 0, rx_single_en = 0;
  logic tx_en = 1, nine_mode = 0, ninth_bit = 0, clk_pol = 0, irq_en = 0;
  logic sdata_out, hold_empty, shift_empty, irq_req;

  int errors = 0, checks = 0;
  bit done = 0;
  bit exp_q[$];

  always #10 clk = ~clk;

  sync_slave_tx #(.DW(DW)) i_sync_slave_tx (.*);

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // driver: writes a word and queues its expected bits
  task automatic send_word(logic [DW-1:0] w, bit expect_out);
    @(negedge clk);
    wr_data = w; wr_hold = 1;
    @(posedge clk);
    @(negedge clk);
    wr_hold = 0;
    if (expect_out) begin
      for (int i = 0; i < DW; i++) exp_q.push_back(w[i]);
      if (nine_mode) exp_q.push_back(ninth_bit);
    end
  endtask

  // master + monitor: n shift-clock periods, compares each bit from the queue
  task automatic clock_bits(int n, bit cmp, string req);
    for (int i = 0; i < n; i++) begin
      sclk_in = ~clk_pol;
      repeat (H) @(negedge clk);
      if (cmp) begin
        if (exp_q.size() == 0) chk({req, " queue empty"}, 1'b0, 1'b1);
        else chk(req, sdata_out, exp_q.pop_front());
      end
      sclk_in = clk_pol;
      repeat (H) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic line;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 shift_empty", shift_empty, 1'b1);
    chk("R1 hold_empty", hold_empty, 1'b1);
    chk("R1 irq_req", irq_req, 1'b0);
    chk("R1 sdata_out", sdata_out, 1'b1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 shift_empty after release", shift_empty, 1'b1);

    // R3..R7, R9: back-to-back words, rising-edge polarity
    irq_en = 1;
    send_word(8'hA5, 1);
    @(negedge clk);
    chk("R3 shift_empty low after load", shift_empty, 1'b0);
    chk("R3 hold_empty back high", hold_empty, 1'b1);
    chk("R7 irq with empty and enable", irq_req, 1'b1);
    send_word(8'h3C, 1);
    chk("R5 hold_empty low while queued", hold_empty, 1'b0);
    chk("R7 irq low while queued", irq_req, 1'b0);
    clock_bits(7, 1, "R4 lsb-first bit");
    chk("R5 hold_empty low before last edge", hold_empty, 1'b0);
    clock_bits(1, 1, "R4 last bit");
    chk("R6 hold_empty after handoff", hold_empty, 1'b1);
    chk("R6 shift_empty after handoff", shift_empty, 1'b0);
    clock_bits(8, 1, "R6 second word bit");
    chk("R9 shift_empty after drain", shift_empty, 1'b1);
    irq_en = 0;
    @(negedge clk);
    chk("R7 irq off when disabled", irq_req, 1'b0);

    // R8 nine-bit mode, falling-edge polarity
    clk_pol = 1; sclk_in = 1;
    repeat (6) @(negedge clk);
    nine_mode = 1;
    ninth_bit = 1;
    send_word(8'h81, 1);
    clock_bits(8, 1, "R8 data bit");
    chk("R8 still busy before ninth", shift_empty, 1'b0);
    clock_bits(1, 1, "R8 ninth bit one");
    chk("R9 empty after ninth", shift_empty, 1'b1);
    ninth_bit = 0;
    send_word(8'hFF, 1);
    clock_bits(9, 1, "R8 ninth bit zero");
    nine_mode = 0;

    // R2 ignored when not enabled
    line = sdata_out;
    tx_en = 0;
    send_word(8'h55, 0);
    chk("R2 tx_en off hold_empty", hold_empty, 1'b1);
    chk("R2 tx_en off shift_empty", shift_empty, 1'b1);
    clock_bits(8, 0, "");
    chk("R2 tx_en off line", sdata_out, line);
    tx_en = 1; rx_cont_en = 1;
    send_word(8'h55, 0);
    clock_bits(8, 0, "");
    chk("R2 receive enabled line", sdata_out, line);
    chk("R2 receive enabled shift_empty", shift_empty, 1'b1);
    rx_cont_en = 0; master_sel = 1;
    send_word(8'h55, 0);
    chk("R2 master selected hold_empty", hold_empty, 1'b1);
    clock_bits(8, 0, "");
    chk("R2 master selected line", sdata_out, line);
    master_sel = 0;

    // R2 flush: a word in flight is dropped when tx_en falls
    send_word(8'h0F, 0);
    clock_bits(2, 0, "");
    chk("R2 busy before flush", shift_empty, 1'b0);
    tx_en = 0;
    repeat (2) @(negedge clk);
    chk("R2 flushed shift_empty", shift_empty, 1'b1);
    tx_en = 1;
    @(negedge clk);
    chk("R2 nothing reloaded", shift_empty, 1'b1);

    finish_up();
  end
endmodule